// File: doc/BRIEF.md
# Clock recovery lock detector

This block watches a clock-recovery loop and decides whether its recovered clock runs at the right frequency. It counts recovered-clock cycles over a window timed by the reference clock. It compares that count with the count implied by a selectable recovered-to-reference ratio. A count outside a tolerance of roughly 1000 ppm means the loop is out of lock. The block then steers the loop to train on the reference. After a fixed number of training windows it hands the loop back to the data. Two consecutive good windows on data raise the lock flag.

A carrier-detect level overrides everything. While it is low, the lock flag is low, the loop follows the reference and the retimed data bit is held at zero. The data path carries one bit per recovered-clock cycle and has no valid/ready handshake: the bit is always accepted and there is no back-pressure. The lock and training outputs are plain levels. The lock flag is not synchronous to the recovered clock.

Top module: `cdr_lock_monitor`

## Requirements
- R1: `ratio_sel_i` selects the recovered-to-reference frequency ratio: 00 selects 8, 01 selects 10, 10 selects 16 and 11 selects 20. With the recovered clock at exactly that ratio, the block reaches lock at every setting.
- R2: A window lasts 2^WIN_LOG2 reference cycles. The expected count is ratio × 2^WIN_LOG2 and the tolerance is the expected count shifted right by TOL_SHIFT bits (with the defaults 11 and 10, about 977 ppm). A count that deviates by more than the tolerance, in either direction, is out of tolerance; any other count is in tolerance.
- R3: `lock_o` rises only after two consecutive accepted in-tolerance windows taken while the loop follows the data. A single good window does not raise it.
- R4: While locked, one out-of-tolerance window drops `lock_o` and sets `train_ref_o` to 1. `train_ref_o` = 1 means follow the reference; 0 means follow the data.
- R5: After a restart or a loss of lock, `train_ref_o` stays 1 for TRAIN_WINDOWS accepted windows and then goes to 0. The first window after a restart is discarded, and so is the window in flight when the loop switches to data. From a restart, `train_ref_o` therefore falls after 5 windows and `lock_o` rises after 8 windows, each followed by a transfer latency of under half a window.
- R6: While `carrier_i` is low, `lock_o` is 0 and `train_ref_o` is 1 with no clock delay, and `data_o` is 0 within three recovered-clock cycles. The block is held in restart; measurement resumes once `carrier_i` returns high.
- R7: While `carrier_i` is high, `data_o` equals `data_i` delayed by one recovered-clock cycle.
- R8: `rst_n` low, or any change of `ratio_sel_i`, returns the block to the out-of-lock training state and restarts the window. After a ratio change, `lock_o` is low within one reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the measurement window |
| rec_clk | input | 1 | Recovered clock being measured; retimes the data |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_i | input | 1 | Carrier-detect level; low forces the safe state |
| ratio_sel_i | input | 2 | Recovered-to-reference ratio select (synchronous to ref_clk) |
| data_i | input | 1 | Raw data bit, one per rec_clk cycle |
| lock_o | output | 1 | Frequency lock flag |
| train_ref_o | output | 1 | Loop training select: 1 reference, 0 data |
| data_o | output | 1 | Gated, retimed data bit |

## Verification
A window result arriving from the recovered-clock domain can land in the same reference cycle as a restart, whether that restart comes from a ratio change or from carrier loss. The restart must win. The bench provokes this by changing the ratio and dropping the carrier while results arrive steadily in the locked state. It judges the outcome by `lock_o` falling at once and by the training and lock milestones then repeating the full 5- and 8-window schedule from zero. The checker also asserts, in every cycle, that a restart leaves the decision logic in training whatever result arrived alongside it.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

  typedef enum logic [1:0] {
    ST_TRAIN = 2'd0,
    ST_ACQ   = 2'd1,
    ST_LOCK  = 2'd2
  } lock_state_e;

  // Ratio select decode, see R1.
  function automatic logic [4:0] ratio_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd8;
      2'b01:   return 5'd10;
      2'b10:   return 5'd16;
      default: return 5'd20;
    endcase
  endfunction

endpackage

// File: rtl/cdr_bit_sync.sv
module cdr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/cdr_win_timer.sv
module cdr_win_timer #(
  parameter int WIN_LOG2 = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic win_end,
  output logic win_tgl
);
  logic [WIN_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      win_tgl <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == '1) win_tgl <= ~win_tgl;
    end
  end

  assign win_end = !restart && (cnt == '1);
endmodule

// File: rtl/cdr_rec_counter.sv
module cdr_rec_counter #(
  parameter int CNT_W       = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_tgl_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             cap_tgl_o
);
  logic tgl_s, tgl_d, evt;
  logic [CNT_W-1:0] cnt;

  cdr_bit_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
    .clk(clk), .rst_n(rst_n), .d(win_tgl_i), .q(tgl_s)
  );

  assign evt = tgl_s ^ tgl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_d     <= 1'b0;
      cnt       <= '0;
      cap_o     <= '0;
      cap_tgl_o <= 1'b0;
    end else begin
      tgl_d <= tgl_s;
      if (evt) begin
        cap_o     <= cnt;
        cnt       <= {{(CNT_W-1){1'b0}}, 1'b1};
        cap_tgl_o <= ~cap_tgl_o;
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdr_lock_judge.sv
module cdr_lock_judge
  import cdr_lock_pkg::*;
#(
  parameter int WIN_LOG2      = 11,
  parameter int TOL_SHIFT     = 10,
  parameter int TRAIN_WINDOWS = 4,
  parameter int CNT_W         = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             win_end,
  input  logic             res_valid,
  input  logic [CNT_W-1:0] res_cnt,
  input  logic [4:0]       ratio,
  output lock_state_e      state_o,
  output logic             res_use_o,
  output logic             res_bad_o,
  output logic             lock_o,
  output logic             train_o
);
  localparam int TC_W = $clog2(TRAIN_WINDOWS + 1);

  logic [CNT_W-1:0] exp_cnt, tol_cnt, dev_cnt;
  logic [1:0]       ends_seen;
  logic [TC_W-1:0]  train_cnt;
  logic             good_once;
  lock_state_e      state;

  assign exp_cnt   = CNT_W'(ratio) << WIN_LOG2;
  assign tol_cnt   = exp_cnt >> TOL_SHIFT;
  assign dev_cnt   = (res_cnt >= exp_cnt) ? (res_cnt - exp_cnt) : (exp_cnt - res_cnt);
  assign res_bad_o = dev_cnt > tol_cnt;
  // A result counts only if its whole window lies after the last restart or handover.
  assign res_use_o = res_valid && (ends_seen == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_TRAIN;
      ends_seen <= 2'd0;
      train_cnt <= '0;
      good_once <= 1'b0;
    end else if (restart) begin
      state     <= ST_TRAIN;
      ends_seen <= 2'd0;
      train_cnt <= '0;
      good_once <= 1'b0;
    end else begin
      if (win_end && ends_seen != 2'd2) ends_seen <= ends_seen + 2'd1;
      if (res_use_o) begin
        case (state)
          ST_TRAIN: begin
            if (train_cnt == TC_W'(TRAIN_WINDOWS - 1)) begin
              state     <= ST_ACQ;
              train_cnt <= '0;
              good_once <= 1'b0;
              ends_seen <= 2'd0;
            end else begin
              train_cnt <= train_cnt + 1'b1;
            end
          end
          ST_ACQ: begin
            if (res_bad_o) begin
              state     <= ST_TRAIN;
              train_cnt <= '0;
              good_once <= 1'b0;
            end else if (good_once) begin
              state <= ST_LOCK;
            end else begin
              good_once <= 1'b1;
            end
          end
          default: begin
            if (res_bad_o) begin
              state     <= ST_TRAIN;
              train_cnt <= '0;
              good_once <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign state_o = state;
  assign lock_o  = (state == ST_LOCK);
  assign train_o = (state == ST_TRAIN);
endmodule

// File: rtl/cdr_lock_monitor.sv
module cdr_lock_monitor
  import cdr_lock_pkg::*;
#(
  parameter int WIN_LOG2      = 11,
  parameter int TOL_SHIFT     = 10,
  parameter int TRAIN_WINDOWS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       ref_clk,
  input  logic       rec_clk,
  input  logic       rst_n,
  input  logic       carrier_i,
  input  logic [1:0] ratio_sel_i,
  input  logic       data_i,
  output logic       lock_o,
  output logic       train_ref_o,
  output logic       data_o
);
  localparam int CNT_W = WIN_LOG2 + 6;

  logic             cd_ref_s, cd_rec_s;
  logic [1:0]       sel_q;
  logic             restart;
  logic             win_end, win_tgl;
  logic [CNT_W-1:0] cap_cnt;
  logic             cap_tgl, cap_tgl_s, cap_tgl_d, res_valid;
  logic             res_use, res_bad, lock_q, train_q;
  logic             data_q;
  lock_state_e      st;

  cdr_bit_sync #(.STAGES(SYNC_STAGES)) u_cd_ref (
    .clk(ref_clk), .rst_n(rst_n), .d(carrier_i), .q(cd_ref_s)
  );
  cdr_bit_sync #(.STAGES(SYNC_STAGES)) u_cd_rec (
    .clk(rec_clk), .rst_n(rst_n), .d(carrier_i), .q(cd_rec_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'b00;
    else        sel_q <= ratio_sel_i;
  end

  assign restart = (ratio_sel_i != sel_q) || !cd_ref_s;

  cdr_win_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk(ref_clk), .rst_n(rst_n), .restart(restart),
    .win_end(win_end), .win_tgl(win_tgl)
  );

  cdr_rec_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_rec_cnt (
    .clk(rec_clk), .rst_n(rst_n), .win_tgl_i(win_tgl),
    .cap_o(cap_cnt), .cap_tgl_o(cap_tgl)
  );

  cdr_bit_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(cap_tgl), .q(cap_tgl_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cap_tgl_d <= 1'b0;
    else        cap_tgl_d <= cap_tgl_s;
  end

  // cap_cnt has been stable for SYNC_STAGES reference cycles when res_valid fires.
  assign res_valid = cap_tgl_s ^ cap_tgl_d;

  cdr_lock_judge #(
    .WIN_LOG2(WIN_LOG2), .TOL_SHIFT(TOL_SHIFT),
    .TRAIN_WINDOWS(TRAIN_WINDOWS), .CNT_W(CNT_W)
  ) u_judge (
    .clk(ref_clk), .rst_n(rst_n), .restart(restart), .win_end(win_end),
    .res_valid(res_valid), .res_cnt(cap_cnt), .ratio(ratio_of(sel_q)),
    .state_o(st), .res_use_o(res_use), .res_bad_o(res_bad),
    .lock_o(lock_q), .train_o(train_q)
  );

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) data_q <= 1'b0;
    else        data_q <= data_i & cd_rec_s;
  end

  assign data_o      = data_q;
  assign lock_o      = lock_q & carrier_i;
  assign train_ref_o = train_q | ~carrier_i;
endmodule

// File: rtl/cdr_lock_monitor_chk.sv
module cdr_lock_monitor_chk
  import cdr_lock_pkg::*;
(
  input logic        ref_clk,
  input logic        rec_clk,
  input logic        rst_n,
  input logic        cd_ref_s,
  input logic        cd_rec_s,
  input logic        restart,
  input logic        res_use,
  input logic        res_bad,
  input lock_state_e st,
  input logic        lock_q,
  input logic        train_q,
  input logic        data_o
);
  a_r2_good_keeps_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st == ST_LOCK && res_use && !res_bad && !restart) |=> lock_q);

  a_r3_lock_after_good_on_data: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(st == ST_ACQ && res_use && !res_bad && !restart));

  a_r4_single_bad_drops: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st == ST_LOCK && res_use && res_bad && !restart) |=> (!lock_q && train_q));

  a_r5_train_ends_on_result: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(train_q) |-> $past(res_use && !restart));

  a_r6_carrier_low_trains: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !cd_ref_s |=> (train_q && !lock_q));

  a_r6_carrier_low_quiet: assert property (@(posedge rec_clk) disable iff (!rst_n)
    !cd_rec_s |=> !data_o);

  a_r8_restart_wins: assert property (@(posedge ref_clk) disable iff (!rst_n)
    restart |=> (st == ST_TRAIN && !lock_q));
endmodule

bind cdr_lock_monitor cdr_lock_monitor_chk u_chk (
  .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
  .cd_ref_s(cd_ref_s), .cd_rec_s(cd_rec_s), .restart(restart),
  .res_use(res_use), .res_bad(res_bad), .st(st),
  .lock_q(lock_q), .train_q(train_q), .data_o(data_o)
);

// File: tb/cdr_lock_monitor_test.sv
`timescale 1ns/1ps
module cdr_lock_monitor_test;
  localparam int WL = 5;           // window = 32 reference cycles
  localparam int W  = 1 << WL;

  logic       ref_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic       carrier_i = 1'b1, data_i = 1'b0;
  logic [1:0] ratio_sel_i = 2'b00;
  logic       lock_o, train_ref_o, data_o;
  realtime    ref_half = 16.0;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  cdr_lock_monitor #(.WIN_LOG2(WL), .TOL_SHIFT(5), .TRAIN_WINDOWS(4), .SYNC_STAGES(2)) uut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n), .carrier_i(carrier_i),
    .ratio_sel_i(ratio_sel_i), .data_i(data_i), .lock_o(lock_o),
    .train_ref_o(train_ref_o), .data_o(data_o)
  );

  always #2 rec_clk = ~rec_clk;            // 250 MHz recovered clock
  always #(ref_half) ref_clk = ~ref_clk;

  function automatic int bench_ratio(input logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 10;
      2'b10: return 16;
      default: return 20;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_refs(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // Count over one window = 32 * Tref / 4 ns; choose Tref for a count of n.
  task automatic set_count(input int n);
    ref_half = n / 16.0;
  endtask

  initial begin
    int r, n, tol;
    wait_refs(10);
    chk("R8 reset lock", lock_o, 0);
    chk("R8 reset training", train_ref_o, 1);
    chk("R6 reset data", data_o, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      r = bench_ratio(2'(s));
      n = r * W;
      tol = n >> 5;
      if (s != 0) begin
        // R8: ratio change while locked restarts at once
        ratio_sel_i = 2'(s);
        set_count(n);
        wait_refs(2);
        chk($sformatf("R8 ratio change drops lock r%0d", r), lock_o, 0);
        chk($sformatf("R8 ratio change trains r%0d", r), train_ref_o, 1);
      end
      wait_refs(W * 9 / 2 - 2);
      chk($sformatf("R5 training at 4.5 windows r%0d", r), train_ref_o, 1);
      wait_refs(W);
      chk($sformatf("R5 on data at 5.5 windows r%0d", r), train_ref_o, 0);
      wait_refs(2 * W);
      chk($sformatf("R3 one good window no lock r%0d", r), lock_o, 0);
      wait_refs(W);
      chk($sformatf("R1 R3 locked at ratio %0d", r), lock_o, 1);
      set_count(n + tol - 2);
      wait_refs(3 * W);
      chk($sformatf("R2 fast within tolerance r%0d", r), lock_o, 1);
      set_count(n - tol + 2);
      wait_refs(3 * W);
      chk($sformatf("R2 slow within tolerance r%0d", r), lock_o, 1);
      set_count(n + tol + 3);
      wait_refs(W * 5 / 2);
      chk($sformatf("R4 fast outside drops lock r%0d", r), lock_o, 0);
      chk($sformatf("R4 fast outside trains r%0d", r), train_ref_o, 1);
      set_count(n);
      wait_refs(12 * W);
      chk($sformatf("R5 relock after loss r%0d", r), lock_o, 1);
      set_count(n - tol - 3);
      wait_refs(12 * W);
      chk($sformatf("R2 slow outside never locks r%0d", r), lock_o, 0);
      set_count(n);
      wait_refs(10 * W);
      chk($sformatf("R5 relock after slow r%0d", r), lock_o, 1);
    end

    // R7: data retimed by one recovered-clock cycle
    for (int i = 0; i < 32; i++) begin
      logic b;
      b = 1'(32'hA5C3_0F96 >> i);
      @(negedge rec_clk);
      data_i = b;
      @(negedge rec_clk);
      chk($sformatf("R7 data bit %0d", i), int'(data_o), int'(b));
    end

    // R6: carrier loss while locked
    data_i = 1'b1;
    @(negedge rec_clk);
    carrier_i = 1'b0;
    #0.5;
    chk("R6 carrier low lock", lock_o, 0);
    chk("R6 carrier low training", train_ref_o, 1);
    repeat (3) @(negedge rec_clk);
    chk("R6 carrier low data", data_o, 0);
    for (int i = 0; i < 8; i++) begin
      data_i = ~data_i;
      @(negedge rec_clk);
      chk("R6 data stays low", data_o, 0);
    end
    data_i = 1'b1;
    wait_refs(2 * W);
    chk("R6 held out of lock", lock_o, 0);
    carrier_i = 1'b1;
    wait_refs(W * 7 / 2);
    chk("R6 training after carrier return", train_ref_o, 1);
    wait_refs(W * 13 / 2);
    chk("R6 relock after carrier return", lock_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #780us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule